// File: doc/BRIEF.md
# Dual-Mode PCI Grant Controller

This block owns the five active-low grant lines of a PCI host bridge and gives them one of two jobs. When its own arbiter is active, it watches the active-low request lines of up to five external bus masters and hands the bus to one of them at a time. Rotating priority keeps any one master from holding the bus for good. A grant moves only across an idle bus, with one dead cycle between masters. When no master is asking, the grant parks on the master that held it last.

When an outside arbiter is in charge, grant line 0 carries the host's own bus request out of the chip, and request line 0 carries the outside arbiter's grant back in. The host raises its request only while it needs the bus. If the outside arbiter has already left the bus parked on the host, no request goes out and a parked flag is raised instead. The choice between the two jobs comes from a strap that is captured while reset is held, combined with an enable bit from a control register. A change of the enable bit is taken up only on an idle bus cycle.

Top module: `pci_grant_front`

## Requirements
- R1: While reset is applied and after it is released, every grant line reads high (negated) and both host flags read low until a request is acted on.
- R2: At most one grant line is low in any cycle.
- R3: With the internal arbiter active and the bus idle, a grant goes low one clock after the request is seen. The winner is the first requesting master found by searching upward with wrap-around from the index after the most recent owner. After reset, the search starts at master 0. If the current owner and any other master both request, the grant rotates away from the owner.
- R4: In internal mode a grant is held unchanged while FRAME# or IRDY# is low. A grant is withdrawn only on a cycle where both are high.
- R5: When the grant passes from one master to another, there is exactly one cycle with all grant lines high in between.
- R6: In internal mode, when no master requests, the grant stays on the last owner.
- R7: External-arbiter mode is in force when the strap was high on the last clock edge of reset, or when the enable bit reads 0. The enable bit is taken in only on a cycle with FRAME# and IRDY# both high. The strap has no effect once reset is released.
- R8: In external-arbiter mode, grant lines 4 to 1 stay high.
- R9: In external-arbiter mode, grant line 0 goes low one clock after the host-need input is high, as long as the bus is not parked on the host. It returns high one clock after host-need drops.
- R10: In external-arbiter mode, when request line 0 (the incoming grant) is low while the host is not requesting, the bus counts as parked on the host. The parked flag rises, and grant line 0 stays high even if host-need then rises. Parking ends one clock after request line 0 returns high.
- R11: The host-owns flag is high in external-arbiter mode exactly one clock after request line 0 is seen low. In internal mode, both host flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| strap_ext_i | input | 1 | Strap captured during reset; high selects external-arbiter mode |
| arb_en_i | input | 1 | Control-register enable for the internal arbiter; 0 disables it |
| req_n_i | input | 5 | Active-low master requests; bit 0 is the incoming grant in external mode |
| frame_n_i | input | 1 | PCI FRAME#, active low |
| irdy_n_i | input | 1 | PCI IRDY#, active low |
| host_need_i | input | 1 | High while the host needs the bus for a transaction |
| gnt_n_o | output | 5 | Active-low grants; bit 0 is the host bus request in external mode |
| host_owns_o | output | 1 | Host holds the bus from the outside arbiter |
| host_parked_o | output | 1 | Bus is parked on the host without a request from it |

## Verification
The assertions assume that every input is synchronous to the clock and settled before each rising edge, and that the strap is steady across reset. They also treat FRAME# and IRDY# high together as the only idle signature, so they do not try to judge whether a master respects its grant. The bench changes every input one nanosecond after a rising edge and draws random request, bus-activity, host-need and enable-bit patterns inside those rules. A behavioural model tracks the expected grants and flags, including the dead cycle and mode changes that land on idle cycles.

// File: rtl/pci_arb_pkg.sv
`timescale 1ns/1ps
package pci_arb_pkg;

  // Internal arbiter phases
  typedef enum logic [1:0] {
    ARB_NONE  = 2'd0,  // no grant issued yet
    ARB_GRANT = 2'd1,  // one master holds the grant
    ARB_GAP   = 2'd2   // dead cycle before handing over
  } arb_state_e;

endpackage

// File: rtl/pci_arb_rst_sync.sv
`timescale 1ns/1ps
module pci_arb_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_n_o = stage2_q;

endmodule

// File: rtl/pci_arb_mode.sv
`timescale 1ns/1ps
module pci_arb_mode (
  input  logic clk,
  input  logic rst_raw_n,
  input  logic rst_n,
  input  logic strap_i,
  input  logic arb_en_i,
  input  logic bus_idle_i,
  output logic ext_mode_o
);

  logic strap_q;
  logic strap_load;
  logic en_q;
  logic en_d;
  logic en_load;

  // Strap is captured on every edge while the raw reset is low.
  assign strap_load = ~rst_raw_n;

  always_ff @(posedge clk) begin
    if (strap_load) begin
      strap_q <= strap_i;
    end
  end

  // Register enable bit is accepted only across an idle bus.
  assign en_load = bus_idle_i;
  assign en_d    = arb_en_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b1;
    end else if (en_load) begin
      en_q <= en_d;
    end
  end

  assign ext_mode_o = strap_q | ~en_q;

endmodule

// File: rtl/pci_arb_rr.sv
`timescale 1ns/1ps
module pci_arb_rr
  import pci_arb_pkg::*;
#(
  parameter int N = 5,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         active_i,
  input  logic         bus_idle_i,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);

  arb_state_e    st_q, st_d;
  logic [IW-1:0] owner_q, owner_d;
  logic [IW-1:0] target_q, target_d;
  logic [IW-1:0] pick;
  logic          pick_ok;
  logic          upd;

  // Rotating search: scan from owner+N down to owner+1 so the nearest
  // requester after the owner is the last one written.
  always_comb begin
    int idx;
    pick    = owner_q;
    pick_ok = 1'b0;
    for (int k = N; k >= 1; k--) begin
      idx = int'(owner_q) + k;
      if (idx >= N) idx = idx - N;
      if (req_i[idx]) begin
        pick    = IW'(idx);
        pick_ok = 1'b1;
      end
    end
  end

  // Next-state
  always_comb begin
    st_d     = st_q;
    owner_d  = owner_q;
    target_d = target_q;
    if (!active_i) begin
      st_d = ARB_NONE;
    end else begin
      unique case (st_q)
        ARB_NONE: begin
          if (bus_idle_i && pick_ok) begin
            st_d    = ARB_GRANT;
            owner_d = pick;
          end
        end
        ARB_GRANT: begin
          if (bus_idle_i && pick_ok && (pick != owner_q)) begin
            st_d     = ARB_GAP;
            target_d = pick;
          end
        end
        ARB_GAP: begin
          st_d    = ARB_GRANT;
          owner_d = target_q;
        end
        default: st_d = ARB_NONE;
      endcase
    end
  end

  assign upd = active_i | (st_q != ARB_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ARB_NONE;
      owner_q  <= IW'(N - 1);
      target_q <= '0;
    end else if (upd) begin
      st_q     <= st_d;
      owner_q  <= owner_d;
      target_q <= target_d;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_dec
    assign gnt_o[g] = (st_q == ARB_GRANT) && (owner_q == IW'(g));
  end

endmodule

// File: rtl/pci_arb_ext.sv
`timescale 1ns/1ps
module pci_arb_ext (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  input  logic host_need_i,
  input  logic ext_gnt_i,
  output logic bus_req_o,
  output logic owns_o,
  output logic parked_o
);

  logic req_q, req_d;
  logic park_q, park_d;
  logic own_q, own_d;

  // Parked: grant present and held without the host having asked for it.
  always_comb begin
    park_d = 1'b0;
    req_d  = 1'b0;
    own_d  = 1'b0;
    if (active_i) begin
      park_d = ext_gnt_i & (park_q | ~req_q);
      req_d  = host_need_i & ~park_d;
      own_d  = ext_gnt_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      park_q <= 1'b0;
      own_q  <= 1'b0;
    end else begin
      req_q  <= req_d;
      park_q <= park_d;
      own_q  <= own_d;
    end
  end

  assign bus_req_o = req_q;
  assign owns_o    = own_q;
  assign parked_o  = park_q;

endmodule

// File: rtl/pci_grant_front.sv
`timescale 1ns/1ps
module pci_grant_front #(
  parameter int NUM_MASTERS = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   strap_ext_i,
  input  logic                   arb_en_i,
  input  logic [NUM_MASTERS-1:0] req_n_i,
  input  logic                   frame_n_i,
  input  logic                   irdy_n_i,
  input  logic                   host_need_i,
  output logic [NUM_MASTERS-1:0] gnt_n_o,
  output logic                   host_owns_o,
  output logic                   host_parked_o
);

  localparam int UPPER = NUM_MASTERS - 1;

  logic                   rst_sync_n;
  logic                   bus_idle;
  logic                   ext_mode;
  logic [NUM_MASTERS-1:0] int_gnt;
  logic                   bus_req;
  logic                   owns;
  logic                   parked;

  assign bus_idle = frame_n_i & irdy_n_i;

  pci_arb_rst_sync u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_sync_n)
  );

  pci_arb_mode u_mode (
    .clk        (clk),
    .rst_raw_n  (rst_n),
    .rst_n      (rst_sync_n),
    .strap_i    (strap_ext_i),
    .arb_en_i   (arb_en_i),
    .bus_idle_i (bus_idle),
    .ext_mode_o (ext_mode)
  );

  pci_arb_rr #(.N(NUM_MASTERS)) u_rr (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .active_i   (~ext_mode),
    .bus_idle_i (bus_idle),
    .req_i      (~req_n_i),
    .gnt_o      (int_gnt)
  );

  pci_arb_ext u_ext (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .active_i    (ext_mode),
    .host_need_i (host_need_i),
    .ext_gnt_i   (~req_n_i[0]),
    .bus_req_o   (bus_req),
    .owns_o      (owns),
    .parked_o    (parked)
  );

  always_comb begin
    if (ext_mode) begin
      gnt_n_o = {{UPPER{1'b1}}, ~bus_req};
    end else begin
      gnt_n_o = ~int_gnt;
    end
  end

  assign host_owns_o   = ext_mode & owns;
  assign host_parked_o = ext_mode & parked;

endmodule

// File: rtl/pci_grant_front_chk.sv
`timescale 1ns/1ps
module pci_grant_front_chk #(
  parameter int N = 5
) (
  input logic         clk,
  input logic         rst_n,
  input logic         ext_mode,
  input logic         bus_idle,
  input logic [N-1:0] gnt_n_o,
  input logic         host_owns_o,
  input logic         host_parked_o
);

  logic [N-1:0] gnt_a;
  assign gnt_a = ~gnt_n_o;

  // R2
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_a));

  // R4
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_mode && $past(!ext_mode) && ($past(gnt_a) != '0) && (gnt_a != $past(gnt_a)))
      |-> $past(bus_idle));

  // R5
  gap_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_mode && $past(!ext_mode) && (gnt_a != '0) && ($past(gnt_a) != '0))
      |-> (gnt_a == $past(gnt_a)));

  // R8
  upper_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_mode |-> (gnt_n_o[N-1:1] == '1));

  // R10
  parked_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_parked_o |-> gnt_n_o[0]);

  // R11
  int_flags_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_mode |-> (!host_owns_o && !host_parked_o));

  // R7
  mode_on_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_mode != $past(ext_mode)) |-> $past(bus_idle));

endmodule

bind pci_grant_front pci_grant_front_chk #(.N(NUM_MASTERS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .ext_mode      (ext_mode),
  .bus_idle      (bus_idle),
  .gnt_n_o       (gnt_n_o),
  .host_owns_o   (host_owns_o),
  .host_parked_o (host_parked_o)
);

// File: tb/tb_pci_grant_front.sv
`timescale 1ns/1ps
module tb_pci_grant_front;

  localparam int N = 5;

  logic         clk;
  logic         rst_n;
  logic         strap_ext_i;
  logic         arb_en_i;
  logic [N-1:0] req_n_i;
  logic         frame_n_i;
  logic         irdy_n_i;
  logic         host_need_i;
  logic [N-1:0] gnt_n_o;
  logic         host_owns_o;
  logic         host_parked_o;

  int checks;
  int errors;
  string tag;

  pci_grant_front #(.NUM_MASTERS(N)) dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .strap_ext_i   (strap_ext_i),
    .arb_en_i      (arb_en_i),
    .req_n_i       (req_n_i),
    .frame_n_i     (frame_n_i),
    .irdy_n_i      (irdy_n_i),
    .host_need_i   (host_need_i),
    .gnt_n_o       (gnt_n_o),
    .host_owns_o   (host_owns_o),
    .host_parked_o (host_parked_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // ---------------- behavioural reference ----------------
  int m_sync;
  int m_strap;
  int m_en;
  int m_phase;   // 0 idle, 1 granted, 2 dead cycle
  int m_owner;
  int m_next;
  int m_hreq;
  int m_park;
  int m_own;

  function automatic int next_winner(int last, logic [N-1:0] rq_n);
    for (int k = 1; k <= N; k++) begin
      if (!rq_n[(last + k) % N]) return (last + k) % N;
    end
    return -1;
  endfunction

  always @(posedge clk) begin
    int ext, idle, w, g, np;
    if (!rst_n) begin
      m_strap = strap_ext_i;
      m_sync = 0;
      m_en = 1; m_phase = 0; m_owner = N - 1; m_next = 0;
      m_hreq = 0; m_park = 0; m_own = 0;
    end else if (m_sync < 2) begin
      m_sync++;
      m_en = 1; m_phase = 0; m_owner = N - 1; m_next = 0;
      m_hreq = 0; m_park = 0; m_own = 0;
    end else begin
      ext  = m_strap | (m_en == 0);
      idle = frame_n_i & irdy_n_i;
      w    = next_winner(m_owner, req_n_i);
      g    = !req_n_i[0];
      if (ext) begin
        m_phase = 0;
        np = g && (m_park || !m_hreq);
        m_hreq = host_need_i && !np;
        m_park = np;
        m_own = g;
      end else begin
        m_hreq = 0; m_park = 0; m_own = 0;
        if (m_phase == 0) begin
          if (idle && w >= 0) begin m_phase = 1; m_owner = w; end
        end else if (m_phase == 1) begin
          if (idle && w >= 0 && w != m_owner) begin m_phase = 2; m_next = w; end
        end else begin
          m_phase = 1; m_owner = m_next;
        end
      end
      if (idle) m_en = arb_en_i;
    end
  end

  function automatic logic [N-1:0] model_gnt();
    logic [N-1:0] v;
    v = '1;
    if (m_strap || m_en == 0) v[0] = !m_hreq;
    else if (m_phase == 1) v[m_owner] = 1'b0;
    return v;
  endfunction

  task automatic cmp();
    logic [N-1:0] eg;
    logic eo, ep;
    int ext;
    if (!rst_n) return;
    ext = m_strap || m_en == 0;
    eg = model_gnt();
    eo = ext && m_own;
    ep = ext && m_park;
    checks++;
    if (gnt_n_o !== eg || host_owns_o !== eo || host_parked_o !== ep) begin
      errors++;
      $display("FAIL %s model: gnt_n=%b owns=%b parked=%b expected gnt_n=%b owns=%b parked=%b",
               tag, gnt_n_o, host_owns_o, host_parked_o, eg, eo, ep);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    cmp();
  endtask

  task automatic expect_out(logic [N-1:0] eg, logic eo, logic ep, string rq);
    checks++;
    if (gnt_n_o !== eg || host_owns_o !== eo || host_parked_o !== ep) begin
      errors++;
      $display("FAIL %s: gnt_n=%b owns=%b parked=%b expected gnt_n=%b owns=%b parked=%b",
               rq, gnt_n_o, host_owns_o, host_parked_o, eg, eo, ep);
    end
  endtask

  task automatic do_reset(logic strap);
    rst_n = 1'b0;
    strap_ext_i = strap;
    repeat (3) step();
    rst_n = 1'b1;
    strap_ext_i = ~strap;   // after release the strap must not matter (R7)
    repeat (3) step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    checks = 0; errors = 0;
    tag = "R1";
    rst_n = 1'b0; strap_ext_i = 1'b0; arb_en_i = 1'b1;
    req_n_i = '1; frame_n_i = 1'b1; irdy_n_i = 1'b1; host_need_i = 1'b0;
    #1;
    do_reset(1'b0);
    expect_out(5'b11111, 1'b0, 1'b0, "R1 after reset");

    // R3: masters 2 and 3 request, search starts at 0 -> master 2
    tag = "R3";
    req_n_i = 5'b10011;
    step();
    expect_out(5'b11011, 1'b0, 1'b0, "R3 first grant");

    // R4: bus busy, only master 3 asks: grant held
    tag = "R4";
    frame_n_i = 1'b0; req_n_i = 5'b10111;
    step(); step();
    expect_out(5'b11011, 1'b0, 1'b0, "R4 hold while busy");
    irdy_n_i = 1'b0; frame_n_i = 1'b1;
    step();
    expect_out(5'b11011, 1'b0, 1'b0, "R4 hold while IRDY low");
    irdy_n_i = 1'b1;

    // R5: dead cycle then master 3
    tag = "R5";
    step();
    expect_out(5'b11111, 1'b0, 1'b0, "R5 gap cycle");
    step();
    expect_out(5'b10111, 1'b0, 1'b0, "R5 next grant");

    // R6: nobody asks -> park on 3
    tag = "R6";
    req_n_i = '1;
    step(); step(); step();
    expect_out(5'b10111, 1'b0, 1'b0, "R6 park on last owner");

    // R3: everyone asks -> rotate 4, then 0
    tag = "R3";
    req_n_i = '0;
    step();
    expect_out(5'b11111, 1'b0, 1'b0, "R5 gap before 4");
    step();
    expect_out(5'b01111, 1'b0, 1'b0, "R3 rotate to 4");
    step(); step();
    expect_out(5'b11110, 1'b0, 1'b0, "R3 wrap to 0");

    // R7: clear enable while busy -> no effect
    tag = "R7";
    arb_en_i = 1'b0; frame_n_i = 1'b0;
    step(); step();
    expect_out(5'b11110, 1'b0, 1'b0, "R7 enable ignored while busy");
    frame_n_i = 1'b1;
    step();
    expect_out(5'b11111, 1'b0, 1'b0, "R8 external mode upper lines high");

    // R9: host asks for the bus
    tag = "R9";
    req_n_i = '1; host_need_i = 1'b1;
    step();
    expect_out(5'b11110, 1'b0, 1'b0, "R9 host request on line 0");
    tag = "R11";
    req_n_i = 5'b11110;
    step();
    expect_out(5'b11110, 1'b1, 1'b0, "R11 host owns");
    host_need_i = 1'b0;
    step();
    expect_out(5'b11111, 1'b1, 1'b0, "R9 request dropped");

    // R10: grant stays with host not asking -> parked
    tag = "R10";
    step();
    expect_out(5'b11111, 1'b1, 1'b1, "R10 parked");
    host_need_i = 1'b1;
    step(); step();
    expect_out(5'b11111, 1'b1, 1'b1, "R10 no request while parked");
    req_n_i = '1;
    step();
    expect_out(5'b11110, 1'b0, 1'b0, "R10 park ends, request goes out");

    // R11: back to internal, flags must drop
    tag = "R11";
    host_need_i = 1'b0; req_n_i = 5'b11110;
    step();
    arb_en_i = 1'b1;
    step();
    expect_out(5'b11111, 1'b0, 1'b0, "R11 flags low in internal mode");
    step();
    expect_out(5'b11110, 1'b0, 1'b0, "R3 internal grant after return");

    // R7: strap high at reset forces external mode
    tag = "R7";
    req_n_i = '1;
    do_reset(1'b1);
    host_need_i = 1'b1;
    step();
    expect_out(5'b11110, 1'b0, 1'b0, "R7 strap selects external mode");
    host_need_i = 1'b0;
    step();

    // R2: random traffic, both modes
    tag = "R2";
    do_reset(1'b0);
    for (int i = 0; i < 3000; i++) begin
      req_n_i     = N'($urandom) | N'($urandom);
      frame_n_i   = ($urandom % 3) != 0;
      irdy_n_i    = ($urandom % 4) != 0;
      if (($urandom % 5) == 0) host_need_i = ~host_need_i;
      if (($urandom % 60) == 0) arb_en_i = ~arb_en_i;
      step();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule